// File: doc/BRIEF.md
# Control Endpoint Transaction Handler

This block holds the device-side transaction state for one USB control endpoint. On its packet side it connects to a simplified serial interface engine. It receives decoded tokens, data packets delivered one byte at a time, an end-of-packet strobe that carries the CRC result and the data PID, and the host's acknowledgement of IN data. It answers with a handshake (ACK, NAK or silence) and, for IN tokens, a byte stream or a zero-length packet. On its firmware side it offers a single-bank byte FIFO with a push port and a pop port, an arm strobe for IN data, three event flags with write-one-to-clear strobes, and a level interrupt.

The handler decodes each setup packet to follow the transfer through its stages. Byte 0 bit 7 gives the direction. Bytes 6 and 7 give the data length, and a length of zero means there is no data stage. The handler keeps the DATA0/DATA1 toggle and forces DATA1 for both status stages. A pending setup packet protects its own FIFO contents. Until firmware has read every setup byte, the setup flag cannot be cleared, and any OUT data is refused.

Top module: `ctl_ep_handler`

## Requirements
- R1: After a SETUP token, a data packet with good CRC, PID DATA0 (rx_pid_d1=0) and exactly 8 bytes is answered with ACK (hs_stb=1, hs_ack=1) on the edge that samples rx_end. On that same edge st_setup sets and the 8 bytes become readable from the FIFO in arrival order.
- R2: irq is registered. One clock after irq_en and any of st_setup, st_out or st_in are high together, irq is 1. One clock after irq_en is 0, irq is 0.
- R3: A fw_clr_setup pulse clears st_setup only when fifo_level is 0. While setup bytes are still unread, the pulse is ignored.
- R4: An OUT data packet with good CRC that arrives while st_setup is set, or while fifo_level is non-zero, is answered with NAK (hs_stb=1, hs_ack=0). Its bytes are not stored.
- R5: An IN token (tok_kind=3) with no data armed is answered with NAK. When data is armed, the FIFO bytes are sent on tx_byte in order, one per cycle with tx_stb high, starting the cycle after the token edge. tx_last marks the final byte.
- R6: The first data-stage packet after a setup uses DATA1, and the PID then alternates after each successful OUT or acknowledged IN. An accepted OUT sets st_out and leaves its bytes readable in order.
- R7: An OUT packet with good CRC but the wrong PID is acknowledged. Its data is discarded, fifo_level stays 0 and st_out is unchanged.
- R8: stage codes are 0 idle, 1 data IN, 2 data OUT, 3 status IN and 4 status OUT. A setup moves stage to 3 if its length is zero, to 1 if bit 7 of byte 0 is set, and to 2 otherwise. An IN token in stage 2 moves it to 3, and an OUT token in stage 1 moves it to 4. A status-stage packet always uses DATA1, and so does a zero-length IN with tx_zlp. Completing either status stage returns stage to 0, and a completed IN sets st_in.
- R9: A SETUP token (tok_kind=1) at any stage flushes the FIFO, clears all three flags and cancels armed IN data before the new setup packet is taken.
- R10: A data packet with a bad CRC (rx_crc_ok=0) gets no handshake. No flag sets, and nothing is left in the FIFO.
- R11: After reset, all flags, irq, hs_stb, tx_stb, fifo_level and stage are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_stb | input | 1 | Token valid for one cycle |
| tok_kind | input | 2 | 1 SETUP, 2 OUT, 3 IN |
| rx_stb | input | 1 | Data byte valid |
| rx_byte | input | 8 | Received data byte |
| rx_end | input | 1 | End of the data packet |
| rx_crc_ok | input | 1 | CRC good, valid with rx_end |
| rx_pid_d1 | input | 1 | Data PID is DATA1, valid with rx_end |
| host_ack | input | 1 | Host ACK of sent IN data |
| hs_stb | output | 1 | Handshake to send |
| hs_ack | output | 1 | 1 ACK, 0 NAK |
| tx_stb | output | 1 | IN data byte valid |
| tx_byte | output | 8 | IN data byte |
| tx_last | output | 1 | Final IN byte |
| tx_zlp | output | 1 | Send zero-length IN packet |
| tx_pid_d1 | output | 1 | IN packet uses DATA1 |
| fw_wr | input | 1 | Firmware push to FIFO |
| fw_wdata | input | 8 | Firmware push data |
| fw_rd | input | 1 | Firmware pop from FIFO |
| fw_rdata | output | 8 | Popped byte, valid the cycle after fw_rd |
| fw_arm | input | 1 | FIFO contents form the next IN packet |
| fw_clr_setup | input | 1 | Clear setup flag |
| fw_clr_out | input | 1 | Clear OUT flag |
| fw_clr_in | input | 1 | Clear IN-complete flag |
| irq_en | input | 1 | Interrupt enable |
| st_setup | output | 1 | Setup received |
| st_out | output | 1 | OUT data received |
| st_in | output | 1 | IN transfer complete |
| fifo_level | output | AW+1 | Bytes held in FIFO |
| stage | output | 3 | Transfer stage code |
| irq | output | 1 | Level interrupt |

## Verification
The setup path is driven with several request shapes: read with a non-zero length, write with a non-zero length, zero length, and a length set only in its high byte. These separate the direction decode from the length decode and show whether both length bytes are taken into account. OUT packets are sent with the right PID, the wrong PID, a bad CRC, while a setup is pending and while earlier data is unread. These cases tell the accept, discard, silent-drop and refuse paths apart. Full control read and control write sequences then show whether stage progression, the forced DATA1 status packets and the abort on a new SETUP hold together.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
  localparam int BYTE_W    = 8;
  localparam int SETUP_LEN = 8;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_SETUP = 2'd1,
    TK_OUT   = 2'd2,
    TK_IN    = 2'd3
  } tok_e;

  typedef enum logic [2:0] {
    SG_IDLE     = 3'd0,
    SG_DATA_IN  = 3'd1,
    SG_DATA_OUT = 3'd2,
    SG_STAT_IN  = 3'd3,
    SG_STAT_OUT = 3'd4
  } stage_e;

  typedef enum logic [1:0] {
    RX_DROP   = 2'd0,
    RX_SETUP  = 2'd1,
    RX_TAKE   = 2'd2,
    RX_REFUSE = 2'd3
  } rxm_e;
endpackage

// File: rtl/ctl_ep_fifo.sv
module ctl_ep_fifo #(
  parameter  int DW    = 8,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  input  logic          peek,
  input  logic [AW-1:0] peek_off,
  output logic [DW-1:0] q,
  output logic [AW:0]   level
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp;
  logic [AW-1:0] ra;
  logic          full;

  assign level = wp - rp;
  assign full  = (level == (AW+1)'(DEPTH));
  assign ra    = peek ? rp[AW-1:0] + peek_off : rp[AW-1:0];

  always_ff @(posedge clk)
    if (push && !full && !flush) mem[wp[AW-1:0]] <= wdata;

  always_ff @(posedge clk)
    if (pop || peek) q <= mem[ra];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (push && !full) wp <= wp + 1'b1;
      if (pop && level != '0) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/ctl_ep_stage.sv
module ctl_ep_stage
  import ctl_ep_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   setup_ok,
  input  logic   dir_in,
  input  logic   len_zero,
  input  logic   in_tok,
  input  logic   out_tok,
  input  logic   xfer_ok,
  output stage_e stage,
  output logic   expect_d1,
  output logic   in_pid_d1
);
  logic toggle;
  logic in_status;

  assign in_status = (stage == SG_STAT_IN) || (stage == SG_STAT_OUT);
  assign expect_d1 = in_status || toggle;
  // an IN in the data-OUT stage opens the status stage on that same edge
  assign in_pid_d1 = expect_d1 || (stage == SG_DATA_OUT);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage  <= SG_IDLE;
      toggle <= 1'b0;
    end else if (setup_ok) begin
      toggle <= 1'b1;
      if (len_zero)    stage <= SG_STAT_IN;
      else if (dir_in) stage <= SG_DATA_IN;
      else             stage <= SG_DATA_OUT;
    end else if (xfer_ok) begin
      toggle <= ~toggle;
      if (in_status) stage <= SG_IDLE;
    end else if (in_tok && stage == SG_DATA_OUT) begin
      stage <= SG_STAT_IN;
    end else if (out_tok && stage == SG_DATA_IN) begin
      stage <= SG_STAT_OUT;
    end
  end
endmodule

// File: rtl/ctl_ep_handler.sv
module ctl_ep_handler
  import ctl_ep_pkg::*;
#(
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tok_stb,
  input  logic [1:0]        tok_kind,
  input  logic              rx_stb,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rx_end,
  input  logic              rx_crc_ok,
  input  logic              rx_pid_d1,
  input  logic              host_ack,
  output logic              hs_stb,
  output logic              hs_ack,
  output logic              tx_stb,
  output logic [BYTE_W-1:0] tx_byte,
  output logic              tx_last,
  output logic              tx_zlp,
  output logic              tx_pid_d1,
  input  logic              fw_wr,
  input  logic [BYTE_W-1:0] fw_wdata,
  input  logic              fw_rd,
  output logic [BYTE_W-1:0] fw_rdata,
  input  logic              fw_arm,
  input  logic              fw_clr_setup,
  input  logic              fw_clr_out,
  input  logic              fw_clr_in,
  input  logic              irq_en,
  output logic              st_setup,
  output logic              st_out,
  output logic              st_in,
  output logic [AW:0]       fifo_level,
  output logic [2:0]        stage,
  output logic              irq
);
  logic tok_setup, tok_out, tok_in;
  rxm_e rx_mode;
  logic [AW:0] rx_cnt, tx_idx, level;
  logic su_dir, su_len_nz;
  logic tx_busy, in_sent, armed;
  logic [BYTE_W-1:0] q, push_data;
  stage_e stg;
  logic exp_d1, in_pid;
  logic rx_take, setup_ok, out_ok, rx_discard, in_done, xfer_ok;
  logic fifo_flush, fifo_push, fifo_pop;

  always_comb begin
    tok_setup  = tok_stb && (tok_kind == TK_SETUP);
    tok_out    = tok_stb && (tok_kind == TK_OUT);
    tok_in     = tok_stb && (tok_kind == TK_IN);
    rx_take    = rx_stb && (rx_mode == RX_SETUP || rx_mode == RX_TAKE);
    setup_ok   = rx_end && rx_mode == RX_SETUP && rx_crc_ok && !rx_pid_d1
                 && rx_cnt == (AW+1)'(SETUP_LEN);
    out_ok     = rx_end && rx_mode == RX_TAKE && rx_crc_ok && (rx_pid_d1 == exp_d1);
    rx_discard = rx_end && ((rx_mode == RX_SETUP && !setup_ok) ||
                            (rx_mode == RX_TAKE && !out_ok));
    in_done    = host_ack && in_sent && !tx_busy;
    xfer_ok    = out_ok || in_done;
    fifo_flush = tok_setup || rx_discard || in_done;
    fifo_push  = rx_take || fw_wr;
    push_data  = rx_take ? rx_byte : fw_wdata;
    fifo_pop   = fw_rd && !tx_busy;
  end

  ctl_ep_fifo #(.DW(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(fifo_flush), .push(fifo_push), .wdata(push_data),
    .pop(fifo_pop), .peek(tx_busy), .peek_off(tx_idx[AW-1:0]), .q(q), .level(level)
  );

  ctl_ep_stage u_stage (
    .clk(clk), .rst(rst), .setup_ok(setup_ok), .dir_in(su_dir), .len_zero(!su_len_nz),
    .in_tok(tok_in), .out_tok(tok_out), .xfer_ok(xfer_ok),
    .stage(stg), .expect_d1(exp_d1), .in_pid_d1(in_pid)
  );

  // packet receive bookkeeping and setup field capture
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_mode   <= RX_DROP;
      rx_cnt    <= '0;
      su_dir    <= 1'b0;
      su_len_nz <= 1'b0;
    end else if (tok_setup) begin
      rx_mode   <= RX_SETUP;
      rx_cnt    <= '0;
      su_len_nz <= 1'b0;
    end else if (tok_out) begin
      rx_mode <= (st_setup || level != '0) ? RX_REFUSE : RX_TAKE;
      rx_cnt  <= '0;
    end else if (rx_end) begin
      rx_mode <= RX_DROP;
    end else if (rx_stb && rx_mode != RX_DROP) begin
      if (rx_cnt != (AW+1)'(DEPTH)) rx_cnt <= rx_cnt + 1'b1;
      if (rx_mode == RX_SETUP) begin
        if (rx_cnt == '0) su_dir <= rx_byte[BYTE_W-1];
        if ((rx_cnt == (AW+1)'(6) || rx_cnt == (AW+1)'(7)) && rx_byte != '0)
          su_len_nz <= 1'b1;
      end
    end
  end

  // handshakes
  always_ff @(posedge clk) begin
    if (rst) begin
      hs_stb <= 1'b0;
      hs_ack <= 1'b0;
    end else begin
      hs_stb <= 1'b0;
      hs_ack <= 1'b0;
      if (rx_end && rx_crc_ok && rx_mode == RX_REFUSE) begin
        hs_stb <= 1'b1;
      end else if (rx_end && rx_crc_ok && (rx_mode == RX_TAKE || setup_ok)) begin
        hs_stb <= 1'b1;
        hs_ack <= 1'b1;
      end else if (tok_in && !armed) begin
        hs_stb <= 1'b1;
      end
    end
  end

  // IN transmit path
  always_ff @(posedge clk) begin
    if (rst || tok_setup) begin
      tx_busy   <= 1'b0;
      tx_idx    <= '0;
      in_sent   <= 1'b0;
      armed     <= 1'b0;
      tx_stb    <= 1'b0;
      tx_last   <= 1'b0;
      tx_zlp    <= 1'b0;
      tx_pid_d1 <= 1'b0;
    end else begin
      tx_stb  <= tx_busy;
      tx_last <= tx_busy && (tx_idx == level - 1'b1);
      tx_zlp  <= 1'b0;
      if (tok_in && armed && !tx_busy) begin
        in_sent   <= 1'b1;
        tx_pid_d1 <= in_pid;
        if (level == '0) begin
          tx_zlp <= 1'b1;
        end else begin
          tx_busy <= 1'b1;
          tx_idx  <= '0;
        end
      end else if (tx_busy) begin
        tx_idx <= tx_idx + 1'b1;
        if (tx_idx == level - 1'b1) tx_busy <= 1'b0;
      end
      if (in_done) begin
        armed   <= 1'b0;
        in_sent <= 1'b0;
      end else if (fw_arm) begin
        armed <= 1'b1;
      end
    end
  end

  // event flags and interrupt
  always_ff @(posedge clk) begin
    if (rst || tok_setup) begin
      st_setup <= 1'b0;
      st_out   <= 1'b0;
      st_in    <= 1'b0;
    end else begin
      if (setup_ok) st_setup <= 1'b1;
      else if (fw_clr_setup && level == '0) st_setup <= 1'b0;
      if (out_ok) st_out <= 1'b1;
      else if (fw_clr_out) st_out <= 1'b0;
      if (in_done) st_in <= 1'b1;
      else if (fw_clr_in) st_in <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= irq_en && (st_setup || st_out || st_in);
  end

  assign tx_byte    = q;
  assign fw_rdata   = q;
  assign fifo_level = level;
  assign stage      = stg;
endmodule

// File: rtl/ctl_ep_chk.sv
module ctl_ep_chk
  import ctl_ep_pkg::*;
#(
  parameter int AW = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        tok_stb,
  input logic [1:0]  tok_kind,
  input logic        rx_end,
  input logic        rx_crc_ok,
  input logic        rx_pid_d1,
  input logic [1:0]  rx_mode,
  input logic [AW:0] rx_cnt,
  input logic        hs_stb,
  input logic        hs_ack,
  input logic        tx_stb,
  input logic        tx_zlp,
  input logic        tx_pid_d1,
  input logic        st_setup,
  input logic [AW:0] level,
  input logic [2:0]  stage,
  input logic        irq_en,
  input logic        irq
);
  logic good_setup_end;
  assign good_setup_end = rx_end && rx_crc_ok && !rx_pid_d1 && rx_mode == 2'(RX_SETUP)
                          && rx_cnt == (AW+1)'(SETUP_LEN);

  AST_SETUP_ACKED: assert property (@(posedge clk) disable iff (rst)
    good_setup_end |=> hs_stb && hs_ack); // R1
  AST_SETUP_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    good_setup_end |=> st_setup); // R1
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (st_setup && irq_en) |=> irq); // R2
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (st_setup && level != '0 && !(tok_stb && tok_kind == 2'(TK_SETUP))) |=> st_setup); // R3
  AST_REFUSE_NAK: assert property (@(posedge clk) disable iff (rst)
    (rx_end && rx_crc_ok && rx_mode == 2'(RX_REFUSE)) |=> hs_stb && !hs_ack); // R4
  AST_BAD_CRC_SILENT: assert property (@(posedge clk) disable iff (rst)
    (rx_end && !rx_crc_ok && !tok_stb) |=> !hs_stb); // R10
  AST_TX_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_stb, tx_zlp, hs_stb})); // R5
  AST_STATUS_ZLP_D1: assert property (@(posedge clk) disable iff (rst)
    (tx_zlp && stage == 3'(SG_STAT_IN)) |-> tx_pid_d1); // R8
endmodule

bind ctl_ep_handler ctl_ep_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tok_stb(tok_stb), .tok_kind(tok_kind),
  .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .rx_pid_d1(rx_pid_d1),
  .rx_mode(rx_mode), .rx_cnt(rx_cnt), .hs_stb(hs_stb), .hs_ack(hs_ack),
  .tx_stb(tx_stb), .tx_zlp(tx_zlp), .tx_pid_d1(tx_pid_d1),
  .st_setup(st_setup), .level(fifo_level), .stage(stage),
  .irq_en(irq_en), .irq(irq)
);

// File: tb/sim_ctl_ep_handler.sv
module sim_ctl_ep_handler;
  localparam int CLK_NS = 10;
  localparam int DEPTH  = 64;
  localparam int AW     = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tok_stb = 0, rx_stb = 0, rx_end = 0, rx_crc_ok = 0, rx_pid_d1 = 0, host_ack = 0;
  logic [1:0] tok_kind = 0;
  logic [7:0] rx_byte = 0, fw_wdata = 0;
  logic fw_wr = 0, fw_rd = 0, fw_arm = 0, fw_clr_setup = 0, fw_clr_out = 0, fw_clr_in = 0;
  logic irq_en = 0;
  logic hs_stb, hs_ack, tx_stb, tx_last, tx_zlp, tx_pid_d1;
  logic [7:0] tx_byte, fw_rdata;
  logic st_setup, st_out, st_in, irq;
  logic [AW:0] fifo_level;
  logic [2:0] stage;

  int nchk = 0, nfail = 0;
  logic [7:0] pbuf [16];
  logic seen_hs, seen_ack;
  logic [7:0] rd_val;

  always #(CLK_NS/2) clk = ~clk;

  ctl_ep_handler #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .tok_stb(tok_stb), .tok_kind(tok_kind), .rx_stb(rx_stb),
    .rx_byte(rx_byte), .rx_end(rx_end), .rx_crc_ok(rx_crc_ok), .rx_pid_d1(rx_pid_d1),
    .host_ack(host_ack), .hs_stb(hs_stb), .hs_ack(hs_ack), .tx_stb(tx_stb),
    .tx_byte(tx_byte), .tx_last(tx_last), .tx_zlp(tx_zlp), .tx_pid_d1(tx_pid_d1),
    .fw_wr(fw_wr), .fw_wdata(fw_wdata), .fw_rd(fw_rd), .fw_rdata(fw_rdata),
    .fw_arm(fw_arm), .fw_clr_setup(fw_clr_setup), .fw_clr_out(fw_clr_out),
    .fw_clr_in(fw_clr_in), .irq_en(irq_en), .st_setup(st_setup), .st_out(st_out),
    .st_in(st_in), .fifo_level(fifo_level), .stage(stage), .irq(irq)
  );

  // {byte0, wLength, expected stage}
  localparam logic [26:0] VEC [5] = '{
    {8'h80, 16'd18,    3'd1},
    {8'h00, 16'd4,     3'd2},
    {8'h00, 16'd0,     3'd3},
    {8'h80, 16'h0100,  3'd1},
    {8'hC1, 16'd0,     3'd3}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic token(input logic [1:0] k);
    tok_stb = 1; tok_kind = k;
    tick();
    seen_hs = hs_stb; seen_ack = hs_ack;
    tok_stb = 0; tok_kind = 0;
  endtask

  task automatic send_pkt(input int n, input logic pid, input logic crc);
    for (int i = 0; i < n; i++) begin
      rx_stb = 1; rx_byte = pbuf[i];
      tick();
    end
    rx_stb = 0;
    rx_end = 1; rx_crc_ok = crc; rx_pid_d1 = pid;
    tick();
    seen_hs = hs_stb; seen_ack = hs_ack;
    rx_end = 0; rx_crc_ok = 0; rx_pid_d1 = 0;
  endtask

  task automatic setup_pkt(input logic [7:0] b0, input logic [15:0] len, input logic crc);
    pbuf[0] = b0; pbuf[1] = 8'h06; pbuf[2] = 8'h00; pbuf[3] = 8'h01;
    pbuf[4] = 8'h00; pbuf[5] = 8'h00; pbuf[6] = len[7:0]; pbuf[7] = len[15:8];
    token(2'd1);
    send_pkt(8, 1'b0, crc);
  endtask

  task automatic fw_pop();
    fw_rd = 1; tick(); fw_rd = 0;
    rd_val = fw_rdata;
  endtask

  task automatic fw_push(input logic [7:0] b);
    fw_wr = 1; fw_wdata = b; tick(); fw_wr = 0;
  endtask

  task automatic pulse_clr_setup(); fw_clr_setup = 1; tick(); fw_clr_setup = 0; endtask
  task automatic pulse_clr_out();   fw_clr_out = 1;   tick(); fw_clr_out = 0;   endtask
  task automatic pulse_clr_in();    fw_clr_in = 1;    tick(); fw_clr_in = 0;    endtask
  task automatic pulse_arm();       fw_arm = 1;       tick(); fw_arm = 0;       endtask
  task automatic pulse_hack();      host_ack = 1;     tick(); host_ack = 0;     endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R11 reset state
    check("R11 st_setup", st_setup, 0);
    check("R11 st_out", st_out, 0);
    check("R11 st_in", st_in, 0);
    check("R11 level", fifo_level, 0);
    check("R11 stage", stage, 0);
    check("R11 irq", irq, 0);
    check("R11 hs_stb", hs_stb, 0);
    check("R11 tx_stb", tx_stb, 0);

    // table of setup requests: R1 acceptance, R8 stage decode, R3 clear
    for (int i = 0; i < 5; i++) begin
      setup_pkt(VEC[i][26:19], VEC[i][18:3], 1'b1);
      check("R1 setup ack", {seen_hs, seen_ack}, 2'b11);
      check("R1 setup flag", st_setup, 1);
      check("R1 setup level", fifo_level, 8);
      check("R8 stage after setup", stage, VEC[i][2:0]);
      for (int j = 0; j < 8; j++) begin
        fw_pop();
        if (j == 0) check("R1 byte0", rd_val, VEC[i][26:19]);
        if (j == 6) check("R1 byte6", rd_val, VEC[i][10:3]);
        if (j == 7) check("R1 byte7", rd_val, VEC[i][18:11]);
      end
      pulse_clr_setup();
      check("R3 clear after read", st_setup, 0);
    end

    // R2 interrupt level
    irq_en = 1;
    setup_pkt(8'h00, 16'd0, 1'b1);
    tick();
    check("R2 irq on", irq, 1);
    irq_en = 0;
    tick();
    check("R2 irq gated", irq, 0);

    // R3 clear refused while bytes remain
    for (int j = 0; j < 3; j++) fw_pop();
    pulse_clr_setup();
    check("R3 clear ignored", st_setup, 1);
    for (int j = 0; j < 5; j++) fw_pop();
    pulse_clr_setup();
    check("R3 clear taken", st_setup, 0);

    // R4 OUT refused while setup pending
    setup_pkt(8'h00, 16'd4, 1'b1);
    token(2'd2);
    pbuf[0] = 8'hE0; pbuf[1] = 8'hE1; pbuf[2] = 8'hE2; pbuf[3] = 8'hE3;
    send_pkt(4, 1'b1, 1'b1);
    check("R4 nak pending setup", {seen_hs, seen_ack}, 2'b10);
    check("R4 level kept", fifo_level, 8);
    fw_pop();
    check("R4 setup intact", rd_val, 8'h00);
    for (int j = 0; j < 7; j++) fw_pop();
    pulse_clr_setup();

    // R7 wrong toggle discarded
    token(2'd2);
    pbuf[0] = 8'h55; pbuf[1] = 8'h66;
    send_pkt(2, 1'b0, 1'b1);
    check("R7 ack wrong pid", {seen_hs, seen_ack}, 2'b11);
    check("R7 no out flag", st_out, 0);
    check("R7 level empty", fifo_level, 0);

    // R6 first data packet DATA1
    token(2'd2);
    pbuf[0] = 8'h11; pbuf[1] = 8'h22; pbuf[2] = 8'h33;
    send_pkt(3, 1'b1, 1'b1);
    check("R6 ack data1", {seen_hs, seen_ack}, 2'b11);
    check("R6 out flag", st_out, 1);
    check("R6 level", fifo_level, 3);

    // R4 OUT refused while FIFO unread
    token(2'd2);
    pbuf[0] = 8'h99;
    send_pkt(1, 1'b0, 1'b1);
    check("R4 nak unread", {seen_hs, seen_ack}, 2'b10);
    check("R4 level unread", fifo_level, 3);
    fw_pop(); check("R6 data 0", rd_val, 8'h11);
    fw_pop(); check("R6 data 1", rd_val, 8'h22);
    fw_pop(); check("R6 data 2", rd_val, 8'h33);
    pulse_clr_out();
    check("R6 out cleared", st_out, 0);

    // R6 toggle alternates to DATA0
    token(2'd2);
    pbuf[0] = 8'h44; pbuf[1] = 8'h45;
    send_pkt(2, 1'b0, 1'b1);
    check("R6 ack data0", {seen_hs, seen_ack}, 2'b11);
    check("R6 level second", fifo_level, 2);
    fw_pop(); fw_pop();
    pulse_clr_out();

    // R5 IN unarmed gets NAK; R8 stage moves to status IN
    token(2'd3);
    check("R5 in nak", {seen_hs, seen_ack}, 2'b10);
    check("R8 stage status in", stage, 3);
    pulse_arm();
    token(2'd3);
    check("R8 zlp sent", tx_zlp, 1);
    check("R8 zlp data1", tx_pid_d1, 1);
    pulse_hack();
    check("R8 in complete", st_in, 1);
    check("R8 stage idle", stage, 0);
    pulse_clr_in();

    // control read: R5 data order, R6 DATA1 first, R8 status OUT
    setup_pkt(8'h80, 16'd3, 1'b1);
    for (int j = 0; j < 8; j++) fw_pop();
    pulse_clr_setup();
    fw_push(8'hA1); fw_push(8'hA2); fw_push(8'hA3);
    pulse_arm();
    token(2'd3);
    check("R6 in pid data1", tx_pid_d1, 1);
    for (int j = 0; j < 3; j++) begin
      tick();
      check("R5 tx strobe", tx_stb, 1);
      check("R5 tx byte", tx_byte, 8'hA1 + 8'(j));
      check("R5 tx last", tx_last, (j == 2) ? 1 : 0);
    end
    tick();
    check("R5 tx ends", tx_stb, 0);
    pulse_hack();
    check("R5 in flag", st_in, 1);
    check("R5 level flushed", fifo_level, 0);
    pulse_clr_in();
    token(2'd2);
    check("R8 stage status out", stage, 4);
    send_pkt(0, 1'b1, 1'b1);
    check("R8 status out ack", {seen_hs, seen_ack}, 2'b11);
    check("R8 status out flag", st_out, 1);
    check("R8 back to idle", stage, 0);
    pulse_clr_out();

    // R10 bad CRC setup
    setup_pkt(8'h80, 16'd8, 1'b0);
    check("R10 no handshake", seen_hs, 0);
    check("R10 no flag", st_setup, 0);
    check("R10 nothing stored", fifo_level, 0);

    // R9 new SETUP aborts the transfer
    setup_pkt(8'h00, 16'd4, 1'b1);
    for (int j = 0; j < 8; j++) fw_pop();
    pulse_clr_setup();
    token(2'd2);
    pbuf[0] = 8'h71; pbuf[1] = 8'h72; pbuf[2] = 8'h73; pbuf[3] = 8'h74;
    send_pkt(4, 1'b1, 1'b1);
    check("R9 pre level", fifo_level, 4);
    setup_pkt(8'h80, 16'd0, 1'b1);
    check("R9 level new setup", fifo_level, 8);
    check("R9 out flag cleared", st_out, 0);
    check("R9 stage restart", stage, 3);
    fw_pop();
    check("R9 first byte new", rd_val, 8'h80);

    summary();
    $finish;
  end
endmodule